// File: doc/BRIEF.md
# Double-Buffered Clock Register Window

This block is a byte-wide slave with an asynchronous-SRAM-style bus of 128K x 8, built around a synchronous bus clock. The eight highest addresses open a window onto a timekeeper. Every other address reaches an internal storage model. Reads ripple through combinationally from the address. Writes are captured on the rising clock edge while the chip is selected and write enable is low.

The window shows a user copy of the time fields that is kept apart from the live counters. The counters sit in a neighbouring block. They arrive on `live_time`, and they are loaded through `cnt_load` and `cnt_load_val`. Two control bits decide when the user copy follows the counters:

- A freeze bit pins the copy so that software can read a consistent snapshot.
- A hold bit lets software load a new time, which is committed to the counters when the bit is cleared.

Bit positions that the clock does not use behave as plain memory. A digital supply-fail flag deselects the whole slave.

A four-state machine controls the copy:

- States: `ST_RUN` (copy follows the counters), `ST_FROZEN` (freeze bit set), `ST_LOADING` (hold bit set) and `ST_COMMIT` (a single cycle that pulses the counter load).
- Transitions:
  - run-to-loading when the hold bit is set;
  - run-to-frozen when the freeze bit is set;
  - frozen-to-loading when the hold bit is set;
  - frozen-to-run when the freeze bit clears;
  - loading-to-commit when the hold bit clears;
  - commit-to-loading, commit-to-frozen or commit-to-run, depending on the bits at that time.
- Priority: the hold bit wins over the freeze bit.

Top module: `clkwin_top`

## Requirements
- R1: After reset all eight window registers read 0x00, the machine is in `ST_RUN`, `cnt_load` is low and `osc_stop` and `freq_test` are low.
- R2: Addresses 0x1FFF8 to 0x1FFFF select, in rising order, control, seconds, minutes, hours, day, date, month and year. Every lower address selects the storage model.
- R3: `dq_oe` is high only while `ce_n`=0, `we_n`=1, `oe_n`=0 and `pwr_fail`=0. `dq_out` follows the addressed byte in the same cycle without a clock edge.
- R4: With `ce_n`=0, `we_n`=0 and `pwr_fail`=0, `dq_in` is stored at the addressed location on the rising clock edge.
- R5: In `ST_RUN`, when both control bits 7 and 6 are 0, each clock edge copies the live time into the user copy. Only the field bits are copied: seconds and minutes bits 6:0, hours bits 5:0, day bits 2:0, date bits 5:0, month bits 4:0 and year bits 7:0. `live_time` byte k (bits 8k+7:8k) feeds window offset k+1.
- R6: While control bit 6 (freeze) is 1, the user copy keeps its value and the live time does not alter it.
- R7: While control bit 7 (hold) is 1, the user copy is not refreshed, and values written into it are kept.
- R8: Clearing the hold bit produces exactly one `cnt_load` pulse. `cnt_load_val` carries the user field bits with the R5 masks and the R5 packing, and refresh then resumes.
- R9: Bits outside the R5 field masks keep their written values. This includes control bits 5:0, seconds bit 7 and day bits 7:3.
- R10: `osc_stop` mirrors seconds bit 7 and `freq_test` mirrors day bit 6.
- R11: While `pwr_fail` is 1, no write reaches the storage model or the window and `dq_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| pwr_fail | input | 1 | Supply out of tolerance, deselects the slave |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Data bus drive enable |
| live_time | input | 56 | Live counter fields, seconds in the low byte up to year in the high byte |
| cnt_load | output | 1 | One-cycle load strobe to the counters |
| cnt_load_val | output | 56 | Masked user time fields to load |
| osc_stop | output | 1 | Oscillator stop request |
| freq_test | output | 1 | Frequency test request |

## Verification
The checker watches every cycle for the following:
- The user copy stays stable in the frozen and loading states, and while a supply fail coincides with a halted state.
- `cnt_load` is always a single-cycle pulse that follows a cleared hold bit.
- The bus is never driven during a supply fail.

Some behaviour is visible only through the bench's scenarios:
- The masked field values that reach the counters.
- The survival of spare bits across refreshes.
- The refreshed snapshot after a freeze is released.
- The decode of each window offset against the storage model.

// File: rtl/clkwin_pkg.sv
package clkwin_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_FROZEN,
        ST_LOADING,
        ST_COMMIT
    } win_state_e;

    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 8;
    localparam int OFF_W    = $clog2(NUM_REGS);
    localparam int TIME_W   = BYTE_W * (NUM_REGS - 1);
    localparam int FLAT_W   = BYTE_W * NUM_REGS;

    localparam int OFF_CTRL = 0;
    localparam int OFF_SEC  = 1;
    localparam int OFF_DAY  = 4;

    localparam int BIT_HOLD   = 7;
    localparam int BIT_FREEZE = 6;
    localparam int BIT_OSC    = 7;
    localparam int BIT_FTEST  = 6;

    // Bits of each window register that belong to the counted time.
    function automatic logic [BYTE_W-1:0] field_mask(input int off);
        case (off)
            1:       return 8'h7F;
            2:       return 8'h7F;
            3:       return 8'h3F;
            4:       return 8'h07;
            5:       return 8'h3F;
            6:       return 8'h1F;
            7:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/clkwin_ram.sv
module clkwin_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wdata;
        end
    end

    // Ripple-through read path.
    assign rdata = mem[idx];

endmodule

// File: rtl/clkwin_regs.sv
module clkwin_regs
    import clkwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              refresh_en,
    input  logic [TIME_W-1:0] live_time,
    output logic [FLAT_W-1:0] regs_flat
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [BYTE_W-1:0] MASK = field_mask(g);
        logic [BYTE_W-1:0] val_q;

        if (g == OFF_CTRL) begin : g_ctrl
            // Control byte: never refreshed, all bits software owned.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (wr_en && (wr_off == OFF_W'(g))) begin
                    val_q <= wdata;
                end
            end
        end else begin : g_time
            logic [BYTE_W-1:0] live_b;
            assign live_b = live_time[BYTE_W*(g-1) +: BYTE_W];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (wr_en && (wr_off == OFF_W'(g))) begin
                    val_q <= wdata;
                end else if (refresh_en) begin
                    val_q <= (val_q & ~MASK) | (live_b & MASK);
                end
            end
        end

        assign regs_flat[BYTE_W*g +: BYTE_W] = val_q;
    end

endmodule

// File: rtl/clkwin_fsm.sv
module clkwin_fsm
    import clkwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_bit,
    input  logic       freeze_bit,
    output win_state_e st,
    output logic       refresh_en,
    output logic       load_pulse
);
    win_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (hold_bit) begin
                    st_d = ST_LOADING;
                end else if (freeze_bit) begin
                    st_d = ST_FROZEN;
                end
            end
            ST_FROZEN: begin
                if (hold_bit) begin
                    st_d = ST_LOADING;
                end else if (!freeze_bit) begin
                    st_d = ST_RUN;
                end
            end
            ST_LOADING: begin
                if (!hold_bit) begin
                    st_d = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                if (hold_bit) begin
                    st_d = ST_LOADING;
                end else if (freeze_bit) begin
                    st_d = ST_FROZEN;
                end else begin
                    st_d = ST_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // Outputs: refresh gated directly by the bits so a halt bites at once.
    always_comb begin
        refresh_en = 1'b0;
        load_pulse = 1'b0;
        unique case (st_q)
            ST_RUN:     refresh_en = !hold_bit && !freeze_bit;
            ST_FROZEN:  refresh_en = 1'b0;
            ST_LOADING: refresh_en = 1'b0;
            ST_COMMIT:  load_pulse = 1'b1;
        endcase
    end

    assign st = st_q;

endmodule

// File: rtl/clkwin_top.sv
module clkwin_top
    import clkwin_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_fail,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] dq_in,
    output logic [BYTE_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [TIME_W-1:0] live_time,
    output logic              cnt_load,
    output logic [TIME_W-1:0] cnt_load_val,
    output logic              osc_stop,
    output logic              freq_test
);
    localparam int WIN_HI = ADDR_W - 1;

    logic              win_hit;
    logic [OFF_W-1:0]  reg_off;
    logic              access_ok;
    logic              wr_fire;
    logic              reg_wr;
    logic              ram_wr;
    logic [BYTE_W-1:0] ram_rdata;
    logic [FLAT_W-1:0] regs_flat;
    logic              ctrl_w;
    logic              ctrl_r;
    logic              refresh_en;
    win_state_e        st;

    assign win_hit   = &addr[WIN_HI:OFF_W];
    assign reg_off   = addr[OFF_W-1:0];
    assign access_ok = !ce_n && !pwr_fail;
    assign wr_fire   = access_ok && !we_n;
    assign reg_wr    = wr_fire && win_hit;
    assign ram_wr    = wr_fire && !win_hit;

    clkwin_ram #(
        .AW (RAM_AW),
        .DW (BYTE_W)
    ) u_ram (
        .clk   (clk),
        .wr_en (ram_wr),
        .idx   (addr[RAM_AW-1:0]),
        .wdata (dq_in),
        .rdata (ram_rdata)
    );

    clkwin_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .wr_off     (reg_off),
        .wdata      (dq_in),
        .refresh_en (refresh_en),
        .live_time  (live_time),
        .regs_flat  (regs_flat)
    );

    assign ctrl_w = regs_flat[BYTE_W*OFF_CTRL + BIT_HOLD];
    assign ctrl_r = regs_flat[BYTE_W*OFF_CTRL + BIT_FREEZE];

    clkwin_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_bit   (ctrl_w),
        .freeze_bit (ctrl_r),
        .st         (st),
        .refresh_en (refresh_en),
        .load_pulse (cnt_load)
    );

    for (genvar g = 1; g < NUM_REGS; g++) begin : g_load
        assign cnt_load_val[BYTE_W*(g-1) +: BYTE_W] =
            regs_flat[BYTE_W*g +: BYTE_W] & field_mask(g);
    end

    assign osc_stop  = regs_flat[BYTE_W*OFF_SEC + BIT_OSC];
    assign freq_test = regs_flat[BYTE_W*OFF_DAY + BIT_FTEST];

    assign dq_oe  = access_ok && we_n && !oe_n;
    assign dq_out = win_hit ? regs_flat[BYTE_W*reg_off +: BYTE_W] : ram_rdata;

endmodule

// File: rtl/clkwin_chk.sv
module clkwin_chk
    import clkwin_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_fail,
    input logic              dq_oe,
    input logic              cnt_load,
    input win_state_e        st,
    input logic              ctrl_w,
    input logic              wr_fire,
    input logic [FLAT_W-1:0] regs_flat
);

    p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FROZEN && !wr_fire) |=> $stable(regs_flat));

    p_load_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOADING && !wr_fire) |=> $stable(regs_flat));

    p_single_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> !cnt_load);

    p_load_after_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |-> !$past(ctrl_w));

    p_commit_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COMMIT) |=> (st != ST_COMMIT));

    p_fail_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |-> !dq_oe);

    p_fail_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && st != ST_RUN) |=> $stable(regs_flat));

endmodule

bind clkwin_top clkwin_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_fail  (pwr_fail),
    .dq_oe     (dq_oe),
    .cnt_load  (cnt_load),
    .st        (st),
    .ctrl_w    (ctrl_w),
    .wr_fire   (wr_fire),
    .regs_flat (regs_flat)
);

// File: tb/clkwin_top_tb.sv
module clkwin_top_tb;

    typedef struct {
        logic [7:0] d;
        logic       oe;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_fail = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  dq_in = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic [55:0] live_q = '0;
    logic        cnt_load;
    logic [55:0] cnt_load_val;
    logic        osc_stop;
    logic        freq_test;

    logic        live_wr = 1'b0;
    logic [55:0] live_wv = '0;
    int          load_cnt = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;
    item_t       sb_q[$];
    event        smp;

    always #5 clk = ~clk;

    clkwin_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_fail     (pwr_fail),
        .ce_n         (ce_n),
        .oe_n         (oe_n),
        .we_n         (we_n),
        .addr         (addr),
        .dq_in        (dq_in),
        .dq_out       (dq_out),
        .dq_oe        (dq_oe),
        .live_time    (live_q),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val),
        .osc_stop     (osc_stop),
        .freq_test    (freq_test)
    );

    // Bench model of the neighbouring counter block.
    always @(posedge clk) begin
        if (cnt_load) begin
            live_q   <= cnt_load_val;
            load_cnt <= load_cnt + 1;
        end else if (live_wr) begin
            live_q <= live_wv;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected bus result when the driver signals a sample point.
    initial begin
        forever begin
            @(smp);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check({it.tag, " oe"}, {63'd0, dq_oe}, {63'd0, it.oe});
                if (it.oe) begin
                    check({it.tag, " data"}, {56'd0, dq_out}, {56'd0, it.d});
                end
            end
        end
    end

    task automatic rd(input logic [16:0] a, input logic [7:0] e, input logic eo,
                      input string tag, input logic oen = 1'b0, input logic cen = 1'b0);
        @(negedge clk);
        addr = a;
        ce_n = cen;
        oe_n = oen;
        we_n = 1'b1;
        sb_q.push_back('{d: e, oe: eo, tag: tag});
        #2 -> smp;
        #1;
        @(negedge clk);
        ce_n = 1'b1;
        oe_n = 1'b1;
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        dq_in = d;
        oe_n  = 1'b1;
        ce_n  = 1'b0;
        we_n  = 1'b0;
        @(negedge clk);
        ce_n = 1'b1;
        we_n = 1'b1;
    endtask

    task automatic set_live(input logic [55:0] v);
        @(negedge clk);
        live_wv = v;
        live_wr = 1'b1;
        @(negedge clk);
        live_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [16:0] A_CTRL = 17'h1FFF8;
    localparam logic [16:0] A_SEC  = 17'h1FFF9;
    localparam logic [16:0] A_MIN  = 17'h1FFFA;
    localparam logic [16:0] A_HR   = 17'h1FFFB;
    localparam logic [16:0] A_DAY  = 17'h1FFFC;
    localparam logic [16:0] A_YR   = 17'h1FFFF;

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(A_CTRL, 8'h00, 1'b1, "R1 control");
        rd(A_DAY, 8'h00, 1'b1, "R1 day");
        check("R1 load count", 64'(load_cnt), 64'd0);
        check("R1 osc_stop", {63'd0, osc_stop}, 64'd0);
        check("R1 freq_test", {63'd0, freq_test}, 64'd0);

        // R5 refresh from live counters, R2 offsets
        set_live(56'h99_12_31_05_23_59_25);
        idle(3);
        rd(A_SEC, 8'h25, 1'b1, "R5 seconds");
        rd(A_MIN, 8'h59, 1'b1, "R2 minutes");
        rd(A_HR, 8'h23, 1'b1, "R2 hours");
        rd(A_YR, 8'h99, 1'b1, "R2 year");

        // R9 spare day bits, R10 frequency test
        wr(A_DAY, 8'hF8);
        idle(2);
        rd(A_DAY, 8'hFD, 1'b1, "R9 day spare bits");
        check("R10 freq_test", {63'd0, freq_test}, 64'd1);

        // R6 freeze
        wr(A_CTRL, 8'h40);
        idle(1);
        set_live(56'h99_12_31_05_23_59_26);
        idle(3);
        rd(A_SEC, 8'h25, 1'b1, "R6 frozen seconds");
        wr(A_CTRL, 8'h00);
        idle(3);
        rd(A_SEC, 8'h26, 1'b1, "R5 after release");

        // R7 hold and load
        wr(A_CTRL, 8'h80);
        idle(1);
        set_live(56'h99_12_31_05_23_59_27);
        wr(A_SEC, 8'h90);
        wr(A_MIN, 8'h45);
        wr(A_HR, 8'h08);
        wr(A_YR, 8'h24);
        idle(3);
        rd(A_SEC, 8'h90, 1'b1, "R7 held seconds");
        rd(A_MIN, 8'h45, 1'b1, "R7 held minutes");
        check("R10 osc_stop", {63'd0, osc_stop}, 64'd1);
        check("R7 no load yet", 64'(load_cnt), 64'd0);

        // R8 commit
        wr(A_CTRL, 8'h00);
        idle(4);
        check("R8 single load", 64'(load_cnt), 64'd1);
        check("R8 loaded value", {8'd0, live_q}, {8'd0, 56'h24_12_31_05_08_45_10});
        rd(A_SEC, 8'h90, 1'b1, "R9 osc bit kept");
        rd(A_YR, 8'h24, 1'b1, "R8 year after commit");

        // R9 control spare bits do not halt
        wr(A_CTRL, 8'h3F);
        idle(1);
        rd(A_CTRL, 8'h3F, 1'b1, "R9 control spare");
        set_live(56'h24_12_31_05_08_45_11);
        idle(3);
        rd(A_SEC, 8'h91, 1'b1, "R5 refresh with spare set");

        // R4 storage model, R2 boundary below window
        wr(17'h00010, 8'hA5);
        wr(17'h1FFF7, 8'h3C);
        rd(17'h00010, 8'hA5, 1'b1, "R4 ram low");
        rd(17'h1FFF7, 8'h3C, 1'b1, "R2 ram below window");
        rd(A_CTRL, 8'h3F, 1'b1, "R2 window untouched");

        // R3 output enable gating
        rd(17'h00010, 8'h00, 1'b0, "R3 oe_n high", 1'b1, 1'b0);
        rd(17'h00010, 8'h00, 1'b0, "R3 ce_n high", 1'b0, 1'b1);

        // R11 supply fail
        pwr_fail = 1'b1;
        wr(17'h00010, 8'h00);
        wr(A_CTRL, 8'hC0);
        rd(17'h00010, 8'h00, 1'b0, "R11 bus quiet");
        @(negedge clk);
        pwr_fail = 1'b0;
        rd(17'h00010, 8'hA5, 1'b1, "R11 ram kept");
        rd(A_CTRL, 8'h3F, 1'b1, "R11 control kept");
        check("R11 no extra load", 64'(load_cnt), 64'd1);

        idle(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (any R) actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule